// File: doc/BRIEF.md
# Multi-Slope Integrating ADC Sequencer

This block is the digital timing core of a multi-slope integrating converter. A start strobe opens a run-up window of a programmable number of modulation periods. The analog input stays connected to the integrator for the whole window. At the start of each period the block looks at the synchronized comparator and switches in one of two fixed reference patterns, so that the integrator is pushed back towards zero. The window is normally set to one 50 Hz line cycle (20 ms, for example 1000 periods of 320 cycles at 16 MHz). Averaging over a longer time is done by running several conversions.

When the window closes, the input is disconnected and the remaining charge is run down in two steps. A fast reference runs until the comparator flips. A slow reference, about one tenth of that rate, then runs in the opposite direction until the comparator flips back. The block then requests one sample from an auxiliary residual ADC. It reports the pattern counts, both slope durations and the residual code as one result record. Because an error at the end of the fast slope costs about ten times as much slow-slope time, the fast slope stops a fixed and short number of cycles after the comparator edge.

Each slope has a programmable timeout. If a slope runs past it, the conversion ends with an overrange flag and every switch open. A new start is accepted only after the previous result has been acknowledged.

Top module: `msadc_seq`

## Requirements
- R1: The raw comparator passes through a two-register synchronizer before any decision. After a raw change that ends the fast slope, the fast pattern is on the switches for exactly two more clock cycles, and the next pattern appears from the third rising edge onward.
- R2: Switch bits are: bit0 input, bit1 fast positive reference, bit2 fast negative reference, bit3 slow positive reference, bit4 slow negative reference. Run-up lasts `cfg_periods` periods of `cfg_period` cycles each. In each period the switch value is 5'b00101 if the synchronized comparator was high when the period began, and 5'b00011 if it was low. The value stays constant for the whole period, and the input bit is set only during run-up.
- R3: `rslt_cnt_neg` equals the number of run-up periods that used 5'b00101, and `rslt_cnt_pos` the number that used 5'b00011. The two sum to `cfg_periods`.
- R4: The fast slope follows run-up with the input open. It uses 5'b00100 if the synchronized comparator was high at the end of run-up and 5'b00010 if it was low. `rslt_fast` equals the number of cycles the fast pattern was applied.
- R5: The slow slope follows the fast slope in the opposite direction: 5'b01000 after 5'b00100, and 5'b10000 after 5'b00010. It ends when the comparator returns to its run-up-end level. `rslt_slow` equals the number of cycles the slow pattern was applied.
- R6: After a completed slow slope, `res_conv` pulses for one cycle with all switches open. The code presented with `res_valid` is reported as `rslt_res`.
- R7: `result_valid` is a one-cycle pulse, once per conversion. All result outputs then hold until `rd_ack`.
- R8: If the fast or slow slope sees no crossing, it ends after exactly `cfg_fast_to` or `cfg_slow_to` cycles respectively. In that case `rslt_ovr` is 1, no `res_conv` is issued and the switches return to 5'b00000.
- R9: While a result is unacknowledged, `start` has no effect and the switches stay open. After `rd_ack`, the next `start` is accepted.
- R10: After reset the switches are 5'b00000 and `res_conv` and `result_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw | input | 1 | Asynchronous integrator comparator (1 = integrator above zero) |
| start | input | 1 | Conversion start strobe |
| rd_ack | input | 1 | Result read acknowledge |
| cfg_period | input | CNT_W | Clock cycles per modulation period |
| cfg_periods | input | CNT_W | Run-up length in periods |
| cfg_fast_to | input | CNT_W | Fast-slope timeout in cycles |
| cfg_slow_to | input | CNT_W | Slow-slope timeout in cycles |
| sw_ctrl | output | 5 | Integrator switch controls |
| res_conv | output | 1 | Residual ADC convert strobe |
| res_valid | input | 1 | Residual ADC code valid |
| res_code | input | RES_W | Residual ADC code |
| result_valid | output | 1 | One-cycle result strobe |
| rslt_ovr | output | 1 | Overrange abort flag |
| rslt_cnt_neg | output | CNT_W | Run-up periods with negative reference pattern |
| rslt_cnt_pos | output | CNT_W | Run-up periods with positive reference pattern |
| rslt_fast | output | CNT_W | Fast-slope cycles |
| rslt_slow | output | CNT_W | Slow-slope cycles |
| rslt_res | output | RES_W | Captured residual code |

## Verification
The assertions assume the following about the inputs. Configuration values are at least one and do not change during a conversion. `res_valid` arrives only after a `res_conv` request, and `rd_ack` is given only while a result is held. The stimulus writes configuration only between conversions. It uses a residual ADC model that answers each request exactly once, a few cycles later, and it acknowledges only after it has seen the result strobe. The comparator is driven on falling edges, so the synchronizer never samples it while it is changing.

// File: rtl/msadc_pkg.sv
// Shared definitions for the multi-slope sequencer: sequencer states and
// switch bit positions. Assumes a five-bit switch word.
package msadc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUNUP,
        ST_FAST,
        ST_SLOW,
        ST_RES_REQ,
        ST_RES_WAIT,
        ST_HOLD
    } seq_state_t;

    localparam int SW_W  = 5;
    localparam int SW_IN = 0;   // input resistor
    localparam int SW_RP = 1;   // fast positive reference
    localparam int SW_RN = 2;   // fast negative reference
    localparam int SW_SP = 3;   // slow positive reference
    localparam int SW_SN = 4;   // slow negative reference
endpackage

// File: rtl/msadc_sync.sv
// Shift-register synchronizer that brings the asynchronous comparator into the
// clock domain. Assumes STAGES >= 2; output lags the input by STAGES edges.
module msadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] sh;

    // Shift the raw level through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d_async};
    end

    assign q_sync = sh[STAGES-1];
endmodule

// File: rtl/msadc_runup.sv
// Run-up timer with two-pattern feedback. On go it starts period zero. At each
// period start it latches the synchronized comparator as the pattern choice and
// counts periods per pattern. Assumes period and n_periods are at least 1 and
// stay stable while active.
module msadc_runup #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             cmp_s,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] n_periods,
    output logic             active,
    output logic             pat_neg,
    output logic             done,
    output logic [CNT_W-1:0] cnt_neg,
    output logic [CNT_W-1:0] cnt_pos
);
    logic [CNT_W-1:0] ph;
    logic [CNT_W-1:0] per;
    logic             ph_last;
    logic             per_last;

    assign ph_last  = (ph == period - 1'b1);
    assign per_last = (per == n_periods - 1'b1);
    assign done     = active && ph_last && per_last;

    // Period phase, period index, pattern choice and per-pattern counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            ph      <= '0;
            per     <= '0;
            pat_neg <= 1'b0;
            cnt_neg <= '0;
            cnt_pos <= '0;
        end else if (go) begin
            active  <= 1'b1;
            ph      <= '0;
            per     <= '0;
            pat_neg <= cmp_s;
            cnt_neg <= cmp_s ? CNT_W'(1) : '0;
            cnt_pos <= cmp_s ? '0 : CNT_W'(1);
        end else if (active) begin
            if (ph_last) begin
                ph <= '0;
                if (per_last) begin
                    active <= 1'b0;
                end else begin
                    per     <= per + 1'b1;
                    pat_neg <= cmp_s;
                    if (cmp_s) cnt_neg <= cnt_neg + 1'b1;
                    else       cnt_pos <= cnt_pos + 1'b1;
                end
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    AST_PATTERN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ph != '0) |-> $stable(pat_neg)); // R2

    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $past(active)) |-> (cnt_neg + cnt_pos == n_periods)); // R3
endmodule

// File: rtl/msadc_slope.sv
// Slope cycle counter. Cleared on clr and counts while en. expire flags the last
// allowed cycle of a slope. Assumes timeout >= 1 and stable while en.
module msadc_slope #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] timeout,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    // Count the cycles for which the slope is applied.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end

    assign expire = en && (cnt == timeout - 1'b1);

    AST_SLOPE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < timeout)); // R8
endmodule

// File: rtl/msadc_seq.sv
// Sequencer top for a multi-slope integrating ADC. It runs run-up, the fast
// rundown, the slow rundown and the residual sample, then holds a result record
// until acknowledged. Assumes the residual ADC answers once per res_conv and that
// configuration is stable during a conversion.
module msadc_seq
    import msadc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_raw,
    input  logic             start,
    input  logic             rd_ack,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_periods,
    input  logic [CNT_W-1:0] cfg_fast_to,
    input  logic [CNT_W-1:0] cfg_slow_to,
    output logic [4:0]       sw_ctrl,
    output logic             res_conv,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_code,
    output logic             result_valid,
    output logic             rslt_ovr,
    output logic [CNT_W-1:0] rslt_cnt_neg,
    output logic [CNT_W-1:0] rslt_cnt_pos,
    output logic [CNT_W-1:0] rslt_fast,
    output logic [CNT_W-1:0] rslt_slow,
    output logic [RES_W-1:0] rslt_res
);
    seq_state_t state;
    logic       cmp_s;
    logic       dir_hi;
    logic       go;
    logic       ru_active, ru_pat_neg, ru_done;
    logic       fast_exp, slow_exp;
    logic       fast_en, slow_en;

    assign go      = (state == ST_IDLE) && start;
    assign fast_en = (state == ST_FAST);
    assign slow_en = (state == ST_SLOW);

    msadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cmp_raw), .q_sync(cmp_s)
    );

    msadc_runup #(.CNT_W(CNT_W)) u_runup (
        .clk(clk), .rst_n(rst_n), .go(go), .cmp_s(cmp_s),
        .period(cfg_period), .n_periods(cfg_periods),
        .active(ru_active), .pat_neg(ru_pat_neg), .done(ru_done),
        .cnt_neg(rslt_cnt_neg), .cnt_pos(rslt_cnt_pos)
    );

    msadc_slope #(.CNT_W(CNT_W)) u_fast (
        .clk(clk), .rst_n(rst_n), .clr(go), .en(fast_en),
        .timeout(cfg_fast_to), .cnt(rslt_fast), .expire(fast_exp)
    );

    msadc_slope #(.CNT_W(CNT_W)) u_slow (
        .clk(clk), .rst_n(rst_n), .clr(go), .en(slow_en),
        .timeout(cfg_slow_to), .cnt(rslt_slow), .expire(slow_exp)
    );

    // Phase sequencing, rundown direction, result capture and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            dir_hi       <= 1'b0;
            rslt_ovr     <= 1'b0;
            rslt_res     <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            case (state)
                ST_IDLE: if (go) begin
                    state    <= ST_RUNUP;
                    rslt_ovr <= 1'b0;
                end
                ST_RUNUP: if (ru_done) begin
                    state  <= ST_FAST;
                    dir_hi <= cmp_s;
                end
                ST_FAST: begin
                    if (cmp_s != dir_hi) begin
                        state <= ST_SLOW;
                    end else if (fast_exp) begin
                        state        <= ST_HOLD;
                        rslt_ovr     <= 1'b1;
                        result_valid <= 1'b1;
                    end
                end
                ST_SLOW: begin
                    if (cmp_s == dir_hi) begin
                        state <= ST_RES_REQ;
                    end else if (slow_exp) begin
                        state        <= ST_HOLD;
                        rslt_ovr     <= 1'b1;
                        result_valid <= 1'b1;
                    end
                end
                ST_RES_REQ: state <= ST_RES_WAIT;
                ST_RES_WAIT: if (res_valid) begin
                    state        <= ST_HOLD;
                    rslt_res     <= res_code;
                    result_valid <= 1'b1;
                end
                ST_HOLD: if (rd_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Switch word decoded from the registered phase and direction.
    always_comb begin
        sw_ctrl = '0;
        case (state)
            ST_RUNUP: begin
                sw_ctrl[SW_IN] = 1'b1;
                if (ru_pat_neg) sw_ctrl[SW_RN] = 1'b1;
                else            sw_ctrl[SW_RP] = 1'b1;
            end
            ST_FAST: begin
                if (dir_hi) sw_ctrl[SW_RN] = 1'b1;
                else        sw_ctrl[SW_RP] = 1'b1;
            end
            ST_SLOW: begin
                if (dir_hi) sw_ctrl[SW_SP] = 1'b1;
                else        sw_ctrl[SW_SN] = 1'b1;
            end
            default: sw_ctrl = '0;
        endcase
    end

    assign res_conv = (state == ST_RES_REQ);

    AST_INPUT_IN_RUNUP: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ctrl[SW_IN] |-> ru_active); // R2

    AST_CONV_AFTER_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        res_conv |-> ($past(state) == ST_SLOW)); // R6

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |->
        ($stable(rslt_res) && $stable(rslt_fast) && $stable(rslt_slow) &&
         $stable(rslt_cnt_neg) && $stable(rslt_ovr))); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rd_ack) |=> (state == ST_HOLD)); // R9

    AST_ABORT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && rslt_ovr) |-> (sw_ctrl == '0 && !res_conv)); // R8
endmodule

// File: tb/msadc_seq_tb.sv
`timescale 1ns/1ps
module msadc_seq_tb;
    localparam int CW = 16;
    localparam int RW = 12;
    localparam int P  = 8;
    localparam int N  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_raw = 1'b0;
    logic          start = 1'b0;
    logic          rd_ack = 1'b0;
    logic [CW-1:0] cfg_period = CW'(P);
    logic [CW-1:0] cfg_periods = CW'(N);
    logic [CW-1:0] cfg_fast_to = CW'(40);
    logic [CW-1:0] cfg_slow_to = CW'(40);
    logic [4:0]    sw_ctrl;
    logic          res_conv;
    logic          res_valid = 1'b0;
    logic [RW-1:0] res_code = '0;
    logic          result_valid, rslt_ovr;
    logic [CW-1:0] rslt_cnt_neg, rslt_cnt_pos, rslt_fast, rslt_slow;
    logic [RW-1:0] rslt_res;

    int n_checks = 0;
    int n_fail   = 0;
    int conv_cnt = 0;
    int wait_cd  = 0;
    int cycles   = 0;
    logic [RW-1:0] model_code = 12'h5A3;

    always #2.5 clk = ~clk;

    msadc_seq #(.CNT_W(CW), .RES_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .start(start), .rd_ack(rd_ack),
        .cfg_period(cfg_period), .cfg_periods(cfg_periods),
        .cfg_fast_to(cfg_fast_to), .cfg_slow_to(cfg_slow_to),
        .sw_ctrl(sw_ctrl), .res_conv(res_conv), .res_valid(res_valid),
        .res_code(res_code), .result_valid(result_valid), .rslt_ovr(rslt_ovr),
        .rslt_cnt_neg(rslt_cnt_neg), .rslt_cnt_pos(rslt_cnt_pos),
        .rslt_fast(rslt_fast), .rslt_slow(rslt_slow), .rslt_res(rslt_res)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Residual ADC model: answers each convert request three cycles later.
    always @(negedge clk) begin
        res_valid = 1'b0;
        if (wait_cd != 0) begin
            wait_cd--;
            if (wait_cd == 0) begin
                res_valid = 1'b1;
                res_code  = model_code;
            end
        end
        if (res_conv) begin
            conv_cnt++;
            wait_cd = 3;
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    task automatic ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    // One conversion, with the comparator driven from the observed switch patterns.
    task automatic run_conv(input string name, input bit sign0, input int flip_at,
                            input int fast_len, input int slow_len, input bit exp_ovr,
                            input int exp_fast, input int exp_slow);
        int cyc_rn = 0, cyc_rp = 0, ru_c = 0, fast_c = 0, slow_c = 0;
        int rv_cnt = 0, bad = 0, conv0;
        logic [4:0] fpat = '0, spat = '0;
        logic [4:0] exp_fpat, exp_spat;
        bit end_sign, done = 0;
        logic [CW-1:0] c_neg = '0, c_pos = '0, c_fast = '0, c_slow = '0;
        logic [RW-1:0] c_res = '0;
        logic c_ovr = 1'b0;
        end_sign = sign0 ^ (flip_at > 0);
        exp_fpat = end_sign ? 5'b00100 : 5'b00010;
        exp_spat = end_sign ? 5'b01000 : 5'b10000;
        conv0 = conv_cnt;
        model_code = model_code + 12'h111;
        cmp_raw = sign0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000 && !done; i++) begin
            case (sw_ctrl)
                5'b00101, 5'b00011: begin
                    if (sw_ctrl == 5'b00101) cyc_rn++; else cyc_rp++;
                    ru_c++;
                    if (ru_c == flip_at) cmp_raw = ~cmp_raw;
                end
                5'b00100, 5'b00010: begin
                    fast_c++; fpat = sw_ctrl;
                    if (fast_c == fast_len) cmp_raw = ~cmp_raw;
                end
                5'b01000, 5'b10000: begin
                    slow_c++; spat = sw_ctrl;
                    if (slow_c == slow_len) cmp_raw = ~cmp_raw;
                end
                5'b00000: ;
                default: bad++;
            endcase
            if (result_valid) begin
                rv_cnt++;
                done = 1;
                c_neg = rslt_cnt_neg; c_pos = rslt_cnt_pos;
                c_fast = rslt_fast; c_slow = rslt_slow;
                c_res = rslt_res; c_ovr = rslt_ovr;
            end
            @(negedge clk);
        end
        for (int i = 0; i < 4; i++) begin
            if (result_valid) rv_cnt++;
            if (sw_ctrl != 5'b00000) bad++;
            @(negedge clk);
        end
        $display("scenario %s", name);
        chk("R2 pattern legal", bad == 0, bad, 0);
        chk("R2 runup length", cyc_rn + cyc_rp == P * N && cyc_rn % P == 0, cyc_rn + cyc_rp, P * N);
        chk("R3 neg periods", c_neg == CW'(cyc_rn / P), c_neg, cyc_rn / P);
        chk("R3 pos periods", c_pos == CW'(cyc_rp / P), c_pos, cyc_rp / P);
        chk("R4 fast dir", fpat == exp_fpat, fpat, exp_fpat);
        chk("R1 R4 fast ticks", fast_c == exp_fast && c_fast == CW'(fast_c), c_fast, exp_fast);
        chk("R7 one strobe", rv_cnt == 1, rv_cnt, 1);
        chk("R8 ovr flag", c_ovr == exp_ovr, c_ovr, exp_ovr);
        if (exp_ovr) begin
            chk("R8 no convert", conv_cnt == conv0, conv_cnt - conv0, 0);
        end else begin
            chk("R5 slow dir", spat == exp_spat, spat, exp_spat);
            chk("R6 one convert", conv_cnt == conv0 + 1, conv_cnt - conv0, 1);
            chk("R6 residue", c_res == model_code, c_res, model_code);
        end
        if (exp_slow >= 0)
            chk("R5 slow ticks", slow_c == exp_slow && c_slow == CW'(slow_c), c_slow, exp_slow);
    endtask

    task automatic t_reset();
        chk("R10 switches open", sw_ctrl == 5'b00000, sw_ctrl, 0);
        chk("R10 no convert", res_conv == 1'b0, res_conv, 0);
        chk("R10 no strobe", result_valid == 1'b0, result_valid, 0);
    endtask

    // Start while a result is unread must do nothing.
    task automatic t_ignore_start();
        int opened = 0, rv = 0;
        logic [CW-1:0] f0;
        f0 = rslt_fast;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (sw_ctrl != 5'b00000) opened++;
            if (result_valid) rv++;
            @(negedge clk);
        end
        chk("R9 start ignored", opened == 0 && rv == 0, opened, 0);
        chk("R7 result held", rslt_fast == f0, rslt_fast, f0);
        ack();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 start after ack", sw_ctrl[0] == 1'b1, sw_ctrl, 5'b00101);
        for (int i = 0; i < 200 && !result_valid; i++) begin
            if (sw_ctrl == 5'b00100) cmp_raw = 1'b0;
            if (sw_ctrl == 5'b01000) cmp_raw = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
        ack();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        run_conv("basic high", 1'b1, 0, 10, 6, 1'b0, 12, 8);
        t_ignore_start();
        run_conv("mixed runup", 1'b1, 13, 7, 3, 1'b0, 9, 5);
        ack();
        run_conv("low start", 1'b0, 0, 4, 1, 1'b0, 6, 3);
        ack();
        cfg_fast_to = CW'(20);
        run_conv("fast timeout", 1'b1, 0, 0, 0, 1'b1, 20, 0);
        ack();
        cfg_fast_to = CW'(40);
        cfg_slow_to = CW'(15);
        run_conv("slow timeout", 1'b0, 0, 5, 0, 1'b1, 7, 15);
        ack();
        summary();
    end
endmodule